// File: doc/BRIEF.md
# Transfer Byte Counter With Shadow Address

This block keeps the books for one bus data transfer. A 24-bit remaining-byte count runs down and a 32-bit shadow address runs up. Both move together, and only when the surrounding data path pulses a one-cycle strobe saying that a byte really went across the bus. A second host address register may advance on a separate prefetch strobe, so it can run ahead of the data that has actually moved. The shadow address never runs ahead, so it always names the byte that follows the last one committed.

Software loads the count and the host address through a byte-wide register port. Each write to a host address byte also loads the same byte of the shadow address. Software can read every register back. Two status flags are kept. One is set when the count drains to zero, and one is set when a commit arrives at a count of zero and the count wraps. Each flag has its own interrupt enable and is cleared by writing a one to it.

Inside the counter a two-state machine tracks whether any bytes are left. The state ST_IDLE means the count is zero, and ST_RUN means it is not. There are four named transitions:
- LOAD (ST_IDLE to ST_RUN): a byte write makes the count non-zero.
- WRAP (ST_IDLE to ST_RUN): a commit arrives at a count of zero.
- DRAIN (ST_RUN to ST_IDLE): the last byte is committed, or a byte write zeroes the count.
- CLEAR (ST_RUN to ST_IDLE): the clear control bit is written.

Top module: `xfer_tally`

## Requirements
- R1: The register map is laid out as follows. Offsets 0 to 2 hold the count, least significant byte first, read/write. Offsets 3 to 6 hold the host address, least significant byte first, read/write. Offsets 7 to 10 hold the shadow address, least significant byte first, read-only. Offset 11 is control, where bit 0 is clear-count and reads as 0. Offset 12 is status, where bit 0 is done and bit 1 is wrap. Offset 13 holds the interrupt enables, with bit 0 for done and bit 1 for wrap. Every other offset reads as 0.
- R2: Each cycle with commit_stb high lowers the count by exactly one at that clock edge.
- R3: Each commit raises the shadow address by exactly one at the same edge. Writes to offsets 7 to 10 have no effect.
- R4: prefetch_stb raises the host address by one per cycle and leaves the shadow address and the count unchanged.
- R5: When a commit moves the count from 1 to 0, status bit 0 (done) is set.
- R6: When a commit arrives at a count of 0, the count becomes 0xFFFFFF and status bit 1 (wrap) is set.
- R7: Writing 1 to control bit 0 zeroes the count. A commit in the same cycle is dropped: the count and the shadow address do not step, and done is not set.
- R8: Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged. If a flag is set in the same cycle as it is cleared, the set wins.
- R9: irq is high exactly when some status bit and its enable bit are both 1.
- R10: A byte write to the count or to the host address that falls in the same cycle as a commit is applied first. The commit then steps the merged value.
- R11: After reset, every register is 0, the counter is in ST_IDLE and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| commit_stb | input | 1 | One byte confirmed as transferred |
| prefetch_stb | input | 1 | One byte fetched ahead on the host side |
| irq | output | 1 | Interrupt request |

## Verification
A register write and a commit strobe can fall in the same cycle. The bench drives both strobes on one clock edge in several cases: a count byte write, a host address byte write, a clear-count write and a status clear. For each case it reads back the count, the shadow address and the status. It expects the write to be merged before the step, the clear to drop the commit, and a fresh flag to survive its own clear. Back-to-back commits taken from a vector table also check that the count and the shadow address stay in lockstep across byte carries and across the 32-bit address rollover.

// File: rtl/xt_pkg.sv
package xt_pkg;
    localparam int CNT_W  = 24;
    localparam int ADR_W  = 32;
    localparam int REG_AW = 4;
    localparam int STAT_N = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/xt_step_reg.sv
module xt_step_reg #(
    parameter int W    = 32,
    parameter bit DOWN = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W/8-1:0] byte_we,
    input  logic [7:0]     wdata,
    input  logic           clr,
    input  logic           step,
    output logic [W-1:0]   q
);
    localparam int NB = W / 8;

    logic [W-1:0] merged;
    logic [W-1:0] stepped;

    // byte writes land before the step
    always_comb begin
        merged = q;
        for (int i = 0; i < NB; i++) begin
            if (byte_we[i]) merged[i*8 +: 8] = wdata;
        end
    end

    generate
        if (DOWN) begin : g_down
            assign stepped = merged - W'(1);
        end else begin : g_up
            assign stepped = merged + W'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (step)  q <= stepped;
        else            q <= merged;
    end

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && byte_we == '0) |=>
        (q == (DOWN ? $past(q) - W'(1) : $past(q) + W'(1))));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr && byte_we == '0) |=> $stable(q));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/xt_count.sv
module xt_count
    import xt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W/8-1:0] byte_we,
    input  logic [7:0]     wdata,
    input  logic           commit,
    input  logic           clr,
    output logic [W-1:0]   count,
    output logic           commit_eff,
    output logic           done_evt,
    output logic           wrap_evt
);
    localparam int NB = W / 8;

    cnt_state_e   state_q, state_d;
    logic [W-1:0] merged;
    logic [W-1:0] fut;

    assign commit_eff = commit && !clr;

    xt_step_reg #(.W(W), .DOWN(1'b1)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (byte_we),
        .wdata   (wdata),
        .clr     (clr),
        .step    (commit_eff),
        .q       (count)
    );

    always_comb begin
        merged = count;
        for (int i = 0; i < NB; i++) begin
            if (byte_we[i]) merged[i*8 +: 8] = wdata;
        end
        if (clr)             fut = '0;
        else if (commit_eff) fut = merged - W'(1);
        else                 fut = merged;
    end

    // next-state logic: LOAD, WRAP, DRAIN, CLEAR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fut != '0) state_d = ST_RUN;
            ST_RUN:  if (fut == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // event outputs
    always_comb begin
        done_evt = commit_eff && (merged == W'(1));
        wrap_evt = commit_eff && (merged == '0);
    end

    p_state_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) == (count != '0)));

    p_wrap_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (count == '1));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (count == '0 && state_q == ST_IDLE));
endmodule

// File: rtl/xt_status.sv
module xt_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         en_we,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] stat,
    output logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_mask) | set;
            if (en_we) en <= en_bits;
        end
    end

    assign irq = |(stat & en);

    generate
        for (genvar b = 0; b < N; b++) begin : g_chk
            p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_mask[b] && !set[b]) |=> !stat[b]);
            p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
                set[b] |=> stat[b]);
        end
    endgenerate
endmodule

// File: rtl/xfer_tally.sv
module xfer_tally
    import xt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADR_W,
    parameter int RW = REG_AW,
    parameter int SN = STAT_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          commit_stb,
    input  logic          prefetch_stb,
    output logic          irq
);
    localparam int CB     = CW / 8;
    localparam int AB     = AW / 8;
    localparam int O_CNT  = 0;
    localparam int O_HADR = O_CNT + CB;
    localparam int O_SADR = O_HADR + AB;
    localparam int O_CTRL = O_SADR + AB;
    localparam int O_STAT = O_CTRL + 1;
    localparam int O_IEN  = O_STAT + 1;

    logic [CB-1:0] cnt_we;
    logic [AB-1:0] adr_we;
    logic          clr_cnt;
    logic [CW-1:0] count;
    logic [AW-1:0] hadr, sadr;
    logic          commit_eff, done_evt, wrap_evt;
    logic [SN-1:0] stat, en;
    int            a;

    assign a = int'(reg_addr);

    always_comb begin
        for (int i = 0; i < CB; i++) cnt_we[i] = reg_we && (a == O_CNT + i);
        for (int i = 0; i < AB; i++) adr_we[i] = reg_we && (a == O_HADR + i);
    end
    assign clr_cnt = reg_we && (a == O_CTRL) && reg_wdata[0];

    xt_count #(.W(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (cnt_we),
        .wdata      (reg_wdata),
        .commit     (commit_stb),
        .clr        (clr_cnt),
        .count      (count),
        .commit_eff (commit_eff),
        .done_evt   (done_evt),
        .wrap_evt   (wrap_evt)
    );

    xt_step_reg #(.W(AW), .DOWN(1'b0)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (adr_we),
        .wdata   (reg_wdata),
        .clr     (1'b0),
        .step    (prefetch_stb),
        .q       (hadr)
    );

    xt_step_reg #(.W(AW), .DOWN(1'b0)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (adr_we),
        .wdata   (reg_wdata),
        .clr     (1'b0),
        .step    (commit_eff),
        .q       (sadr)
    );

    xt_status #(.N(SN)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      ({wrap_evt, done_evt}),
        .clr_we   (reg_we && (a == O_STAT)),
        .clr_bits (reg_wdata[SN-1:0]),
        .en_we    (reg_we && (a == O_IEN)),
        .en_bits  (reg_wdata[SN-1:0]),
        .stat     (stat),
        .en       (en),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < CB; i++) if (a == O_CNT + i)  reg_rdata = count[i*8 +: 8];
        for (int i = 0; i < AB; i++) if (a == O_HADR + i) reg_rdata = hadr[i*8 +: 8];
        for (int i = 0; i < AB; i++) if (a == O_SADR + i) reg_rdata = sadr[i*8 +: 8];
        if (a == O_STAT) reg_rdata[SN-1:0] = stat;
        if (a == O_IEN)  reg_rdata[SN-1:0] = en;
    end

    p_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_eff && adr_we == '0 && cnt_we == '0) |=>
        ((sadr - $past(sadr)) == ($past(count) - count)
         || ($past(count) == '0 && count == '1)));

    p_irq_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat != $past(stat) || en != $past(en)));
endmodule

// File: tb/xfer_tally_test.sv
module xfer_tally_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       commit_stb = 1'b0;
    logic       prefetch_stb = 1'b0;
    logic       irq;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xfer_tally uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit_stb(commit_stb),
        .prefetch_stb(prefetch_stb), .irq(irq)
    );

    // cnt24, adr32, ncommit8, exp_cnt24, exp_shadow32
    localparam logic [119:0] VEC [4] = '{
        {24'h000010, 32'h1000_0000, 8'd5, 24'h00000B, 32'h1000_0005},
        {24'h000100, 32'h0000_FFFE, 8'd3, 24'h0000FD, 32'h0001_0001},
        {24'h010000, 32'hFFFF_FFFF, 8'd2, 24'h00FFFE, 32'h0000_0001},
        {24'h000003, 32'h1234_5678, 8'd3, 24'h000000, 32'h1234_567B}
    };

    task automatic check(input string req, input longint got, input longint exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input int ad, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(ad); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ad, output logic [7:0] d);
        reg_addr = 4'(ad);
        #1 d = reg_rdata;
    endtask

    task automatic rd_n(input int base, input int nb, output longint v);
        logic [7:0] b;
        v = 0;
        for (int i = 0; i < nb; i++) begin
            rd(base + i, b);
            v = v | (longint'(b) << (8 * i));
        end
    endtask

    task automatic load_cnt(input logic [23:0] c);
        for (int i = 0; i < 3; i++) wr(i, c[i*8 +: 8]);
    endtask

    task automatic load_adr(input logic [31:0] ad);
        for (int i = 0; i < 4; i++) wr(3 + i, ad[i*8 +: 8]);
    endtask

    task automatic commits(input int n);
        @(negedge clk);
        commit_stb = 1'b1;
        repeat (n) @(negedge clk);
        commit_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog R11: got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        longint v;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd_n(0, 3, v);  check("R11 count", v, 0);
        rd_n(3, 4, v);  check("R11 host", v, 0);
        rd_n(7, 4, v);  check("R11 shadow", v, 0);
        rd(12, b);      check("R11 status", b, 0);
        check("R11 irq", irq, 0);

        // R2 R3 vector table
        for (int k = 0; k < 4; k++) begin
            load_cnt(VEC[k][119:96]);
            load_adr(VEC[k][95:64]);
            commits(int'(VEC[k][63:56]));
            rd_n(0, 3, v); check("R2 table count", v, longint'(VEC[k][55:32]));
            rd_n(7, 4, v); check("R3 table shadow", v, longint'(VEC[k][31:0]));
        end
        // last vector drained to zero: done set (R5)
        rd(12, b); check("R5 done after drain", b, 8'h01);
        check("R9 irq masked", irq, 0);
        wr(13, 8'h01);
        check("R9 irq enabled", irq, 1);
        wr(12, 8'h02);
        rd(12, b); check("R8 zero bit keeps done", b, 8'h01);
        wr(12, 8'h01);
        rd(12, b); check("R8 w1c clears done", b, 8'h00);
        check("R9 irq drops", irq, 0);

        // R6 wrap at zero
        commits(1);
        rd_n(0, 3, v); check("R6 wrap count", v, 24'hFFFFFF);
        rd(12, b);     check("R6 wrap flag", b, 8'h02);
        wr(12, 8'h03);

        // R7 clear with concurrent commit
        load_cnt(24'h000005);
        load_adr(32'h0000_0100);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd11; reg_wdata = 8'h01; commit_stb = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; commit_stb = 1'b0;
        rd_n(0, 3, v); check("R7 count cleared", v, 0);
        rd_n(7, 4, v); check("R7 shadow held", v, 32'h100);
        rd(12, b);     check("R7 no done", b, 0);
        rd(11, b);     check("R1 control reads 0", b, 0);

        // R4 prefetch
        @(negedge clk); prefetch_stb = 1'b1;
        repeat (3) @(negedge clk); prefetch_stb = 1'b0;
        rd_n(3, 4, v); check("R4 host advanced", v, 32'h103);
        rd_n(7, 4, v); check("R4 shadow unchanged", v, 32'h100);

        // R3 shadow write ignored
        wr(7, 8'hAA);
        rd_n(7, 4, v); check("R3 shadow read-only", v, 32'h100);
        rd(14, b);     check("R1 unmapped reads 0", b, 0);

        // R10 write merged before commit
        load_cnt(24'h000105);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h20; commit_stb = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; commit_stb = 1'b0;
        rd_n(0, 3, v); check("R10 count merge", v, 24'h00011F);
        rd_n(7, 4, v); check("R10 shadow step", v, 32'h101);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h40; commit_stb = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; commit_stb = 1'b0;
        rd_n(7, 4, v); check("R10 shadow merge", v, 32'h141);

        // R8 set wins over clear in same cycle
        load_cnt(24'h000001);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd12; reg_wdata = 8'h01; commit_stb = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; commit_stb = 1'b0;
        rd(12, b); check("R8 set wins", b, 8'h01);
        check("R9 irq on done", irq, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule